// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block produces the serial-clock timing for an I2C master. A peripheral clock is first divided down to an internal tick, and the tick then paces a small phase sequencer. The sequencer waits a programmable lead-in after a transfer is granted, then alternates between a driven-low phase and a released-high phase. It gives the bit engine a tick enable, a pull-down request for the SCL line, and one-cycle strobes that mark each falling and rising SCL edge.

Two fields of one configuration word set the rate. The low bits are a prescale value that divides the peripheral clock. The field above them is a period step: the SCL period in ticks is a base of twenty, plus eight times the step, plus a rise/fall compensation count that is supplied separately. Software works out these values and keeps them stable while the block runs. The block takes no part in handling SDA.

The high phase counts only while the SCL line is seen high. A target that holds the clock low (clock stretching) therefore lengthens the high phase without breaking the count.

Top module: `scl_rate_gen`

## Requirements
- R1: With prescale value D, the tick output is high on exactly one clock in every D+1 while enabled. After enable is first sampled high, the first tick is consumed on the (D+1)-th rising clock edge.
- R2: The configuration word carries the prescale value D in bits [DIV_W-1:0] and the 6-bit period step S in bits [DIV_W+5:DIV_W]. With the default DIV_W of 3, D is bits [2:0] and S is bits [8:3].
- R3: One SCL period lasts P = 20 + 8·S + C ticks, where C is the compensation input. The low phase lasts ceil(P/2) ticks and the high phase lasts the remaining ticks. So a rise strobe follows a fall strobe by ceil(P/2)·(D+1) clocks, and the next fall strobe follows a rise strobe by (P − ceil(P/2))·(D+1) clocks.
- R4: During the high phase, a tick counts only when the scl_in input is high. Each tick lost while the line is held low delays the next fall strobe by one tick.
- R5: When run is sampled high while the block is idle, the first fall strobe comes after a lead-in of 6 ticks if lead_long is 0, or 17 ticks if lead_long is 1. SCL stays released during the lead-in.
- R6: If run is low when a high phase ends, the block returns to idle. No further fall strobe is issued and SCL stays released.
- R7: While enable is low, the prescaler and the sequencer are held at their start state. On the clock after enable is sampled low, the SCL pull-down and both strobes are low. A later enable and run start again with a full lead-in.
- R8: Each strobe is a one-clock pulse issued on a tick edge. The pull-down output is high in the cycle a fall strobe is visible and low in the cycle a rise strobe is visible. Rise and fall strobes are never high together.
- R9: After reset, the pull-down output, both strobes and the tick output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Interface enable; low holds the block at its start state |
| run | input | 1 | Transfer granted; sampled in idle and at the end of each high phase |
| clk_cfg | input | DIV_W+6 | Packed configuration: period step above prescale value |
| comp_ticks | input | COMP_W | Rise/fall compensation, in ticks |
| lead_long | input | 1 | Selects the 17-tick lead-in instead of the 6-tick one |
| scl_in | input | 1 | Observed level of the SCL line |
| tick | output | 1 | Internal tick enable for the bit engine |
| scl_drive_low | output | 1 | Request to pull SCL low |
| scl_fall_stb | output | 1 | One-cycle pulse at each falling SCL edge |
| scl_rise_stb | output | 1 | One-cycle pulse at each SCL release |

## Verification
The assertions check the local rules on every cycle. Strobes come only on tick edges and never together. A rise strobe only follows a driven-low cycle. A low enable clears the outputs on the next clock. The high-phase count holds while the line is low. The prescaler never ticks on two consecutive clocks when its divisor is above zero. The timing itself can only be shown by the bench scenarios: the exact spacing of the strobes for several prescale, step and compensation settings, both lead-in lengths, how much a stretch delays the next edge, the stop at the end of a high phase, and the clean restart after enable drops.

// File: rtl/scl_div_pkg.sv
// Shared constants and types for the SCL rate divider.
package scl_div_pkg;

    // Fixed part of the SCL period and the tick weight of one period step.
    localparam int BASE_TICKS = 20;
    localparam int SCGD_STEP  = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LOW,
        PH_HIGH
    } phase_e;

endpackage

// File: rtl/scl_tick_prescaler.sv
// Divides the peripheral clock by (div+1) and gives a one-cycle tick enable.
// Assumes that div stays stable while enabled. A low enable restarts the
// count, so the first tick after enabling comes on the (div+1)-th edge.
module scl_tick_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] pre_q;

    // Count clocks from 0 up to div, then wrap around.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre_q <= '0;
        end else if (pre_q == div) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = en && (pre_q == div);

    // R1: with a nonzero stable divisor, ticks never land on two consecutive clocks
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(tick) && $stable(div) && div != '0) |-> !tick);

endmodule

// File: rtl/scl_phase_len.sv
// Works out the SCL period, low-phase and high-phase lengths in ticks from
// the period step and the compensation count. Purely combinational.
module scl_phase_len
    import scl_div_pkg::*;
#(
    parameter int SCGD_W = 6,
    parameter int COMP_W = 6,
    parameter int PER_W  = 10
) (
    input  logic [SCGD_W-1:0] scgd,
    input  logic [COMP_W-1:0] comp,
    output logic [PER_W-1:0]  low_len,
    output logic [PER_W-1:0]  high_len
);

    logic [PER_W-1:0] period;

    // Period = base + step*scgd + compensation.
    assign period   = PER_W'(BASE_TICKS) + PER_W'(scgd) * PER_W'(SCGD_STEP) + PER_W'(comp);
    // The low phase takes the rounded-up half; the high phase takes the rest.
    assign low_len  = (period + PER_W'(1)) >> 1;
    assign high_len = period - low_len;

endmodule

// File: rtl/scl_phase_fsm.sv
// Sequences lead-in, low and high SCL phases on internal ticks.
// Assumes the phase lengths stay stable while running. The high phase counts
// only ticks seen with SCL high (stretch support). A low enable returns it to idle.
module scl_phase_fsm
    import scl_div_pkg::*;
#(
    parameter int PER_W      = 10,
    parameter int LEAD_SHORT = 6,
    parameter int LEAD_LONG  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic             tick,
    input  logic             lead_long,
    input  logic             scl_in,
    input  logic [PER_W-1:0] low_len,
    input  logic [PER_W-1:0] high_len,
    output logic             drive_low,
    output logic             fall_stb,
    output logic             rise_stb
);

    phase_e           st_q;
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] lead_len;

    assign lead_len = lead_long ? PER_W'(LEAD_LONG) : PER_W'(LEAD_SHORT);

    // Phase sequencing: the tick counter, the SCL pull-down and the edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st_q      <= PH_IDLE;
            cnt_q     <= '0;
            drive_low <= 1'b0;
            fall_stb  <= 1'b0;
            rise_stb  <= 1'b0;
        end else begin
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
            case (st_q)
                PH_IDLE: begin
                    if (run) begin
                        st_q  <= PH_LEAD;
                        cnt_q <= '0;
                    end
                end
                PH_LEAD: begin
                    if (tick) begin
                        if (cnt_q == lead_len - 1'b1) begin
                            st_q      <= PH_LOW;
                            cnt_q     <= '0;
                            drive_low <= 1'b1;
                            fall_stb  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (cnt_q == low_len - 1'b1) begin
                            st_q      <= PH_HIGH;
                            cnt_q     <= '0;
                            drive_low <= 1'b0;
                            rise_stb  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick && scl_in) begin
                        if (cnt_q == high_len - 1'b1) begin
                            cnt_q <= '0;
                            if (run) begin
                                st_q      <= PH_LOW;
                                drive_low <= 1'b1;
                                fall_stb  <= 1'b1;
                            end else begin
                                st_q <= PH_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: st_q <= PH_IDLE;
            endcase
        end
    end

    // R8: strobes are only issued on tick edges
    a_r8_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_stb || rise_stb) |-> $past(tick));

    // R8: rise and fall strobes are never high together
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb && rise_stb));

    // R3: a release only follows a driven-low cycle
    a_r3_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> $past(drive_low));

    // R4: a held-low line freezes the high-phase count
    a_r4_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q == PH_HIGH && !scl_in) |=> (cnt_q == $past(cnt_q)));

    // R7: a low enable clears the pull-down and strobes on the next clock
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!drive_low && !fall_stb && !rise_stb));

endmodule

// File: rtl/scl_rate_gen.sv
// Top of the SCL rate divider. Unpacks the configuration word (period step
// above prescale value), drives the tick prescaler, works out the phase
// lengths and sequences the SCL phases. Configuration must stay stable while enabled.
module scl_rate_gen
    import scl_div_pkg::*;
#(
    parameter int DIV_W      = 3,
    parameter int SCGD_W     = 6,
    parameter int COMP_W     = 6,
    parameter int LEAD_SHORT = 6,
    parameter int LEAD_LONG  = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     run,
    input  logic [SCGD_W+DIV_W-1:0]  clk_cfg,
    input  logic [COMP_W-1:0]        comp_ticks,
    input  logic                     lead_long,
    input  logic                     scl_in,
    output logic                     tick,
    output logic                     scl_drive_low,
    output logic                     scl_fall_stb,
    output logic                     scl_rise_stb
);

    localparam int MAX_PER = BASE_TICKS + SCGD_STEP * ((1 << SCGD_W) - 1) + (1 << COMP_W);
    localparam int MAX_LEN = (MAX_PER > LEAD_LONG) ? MAX_PER : LEAD_LONG;
    localparam int PER_W   = $clog2(MAX_LEN + 1);

    logic [DIV_W-1:0]  div_f;
    logic [SCGD_W-1:0] scgd_f;
    logic [PER_W-1:0]  low_len;
    logic [PER_W-1:0]  high_len;

    // Field unpacking: the prescale value sits in the low bits.
    assign div_f  = clk_cfg[DIV_W-1:0];
    assign scgd_f = clk_cfg[SCGD_W+DIV_W-1:DIV_W];

    scl_tick_prescaler #(
        .DIV_W (DIV_W)
    ) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (enable),
        .div   (div_f),
        .tick  (tick)
    );

    scl_phase_len #(
        .SCGD_W (SCGD_W),
        .COMP_W (COMP_W),
        .PER_W  (PER_W)
    ) u_len (
        .scgd     (scgd_f),
        .comp     (comp_ticks),
        .low_len  (low_len),
        .high_len (high_len)
    );

    scl_phase_fsm #(
        .PER_W      (PER_W),
        .LEAD_SHORT (LEAD_SHORT),
        .LEAD_LONG  (LEAD_LONG)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .run       (run),
        .tick      (tick),
        .lead_long (lead_long),
        .scl_in    (scl_in),
        .low_len   (low_len),
        .high_len  (high_len),
        .drive_low (scl_drive_low),
        .fall_stb  (scl_fall_stb),
        .rise_stb  (scl_rise_stb)
    );

endmodule

// File: tb/test_scl_rate_gen.sv
// Scoreboard bench: tasks queue the expected strobes and a negedge monitor
// measures the intervals between them and compares.
module test_scl_rate_gen;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       run = 1'b0;
    logic [8:0] clk_cfg = '0;
    logic [5:0] comp_ticks = '0;
    logic       lead_long = 1'b0;
    logic       scl_hold = 1'b0;
    logic       scl_in;
    logic       tick;
    logic       scl_drive_low;
    logic       scl_fall_stb;
    logic       scl_rise_stb;

    assign scl_in = !scl_drive_low && !scl_hold;

    always #(CLK_P/2) clk = ~clk;

    scl_rate_gen i_scl_rate_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .run           (run),
        .clk_cfg       (clk_cfg),
        .comp_ticks    (comp_ticks),
        .lead_long     (lead_long),
        .scl_in        (scl_in),
        .tick          (tick),
        .scl_drive_low (scl_drive_low),
        .scl_fall_stb  (scl_fall_stb),
        .scl_rise_stb  (scl_rise_stb)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Expected strobes: kind (0 fall, 1 rise), measured in ticks or clocks, value, tag.
    int    q_kind[$];
    bit    q_tk[$];
    int    q_val[$];
    string q_tag[$];

    int stretch_req = 0;
    int stretch_tok = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input bit tk, input int val, input string tag);
        q_kind.push_back(kind);
        q_tk.push_back(tk);
        q_val.push_back(val);
        q_tag.push_back(tag);
    endtask

    // Monitor: measures strobe spacing, pops the expected item and compares it.
    int mon_tk = 0;
    int mon_cyc = 0;
    int hold_left = 0;
    int applied_tok = 0;
    bit run_prev = 1'b0;
    always @(negedge clk) begin
        int kind;
        int ek;
        bit etk;
        int ev;
        string etag;
        int meas;
        if (rst_n) begin
            if (scl_fall_stb || scl_rise_stb) begin
                kind = scl_rise_stb ? 1 : 0;
                if (q_kind.size() == 0) begin
                    chk(1'b0, "R6", kind, -1, "unexpected strobe");
                end else begin
                    ek   = q_kind.pop_front();
                    etk  = q_tk.pop_front();
                    ev   = q_val.pop_front();
                    etag = q_tag.pop_front();
                    meas = etk ? mon_tk : mon_cyc;
                    chk(kind == ek, etag, kind, ek, "strobe kind");
                    chk(meas == ev, etag, meas, ev, "interval");
                    // R8: the pull-down level matches the strobe kind
                    chk(scl_drive_low == (kind == 0), "R8", int'(scl_drive_low), int'(kind == 0), "pull-down at strobe");
                end
                if (kind == 1 && stretch_req > 0 && applied_tok != stretch_tok) begin
                    hold_left   = stretch_req;
                    applied_tok = stretch_tok;
                end
                mon_tk  = 0;
                mon_cyc = 0;
            end
            if (run && !run_prev) mon_tk = 0;
            run_prev = run;
            if (tick) mon_tk++;
            mon_cyc++;
            scl_hold = (hold_left > 0);
            if (hold_left > 0) hold_left--;
        end
    end

    task automatic wait_queue_empty();
        while (q_kind.size() != 0) begin
            @(negedge clk);
            #1;
        end
    endtask

    // R1: first tick position and tick spacing after enable.
    task automatic first_tick(input int d);
        int k;
        @(negedge clk);
        #1;
        clk_cfg = {6'd0, 3'(d)};
        enable  = 1'b1;
        k = 1;
        #1;
        while (!tick && k < 40) begin
            @(negedge clk);
            #1;
            k++;
        end
        chk(k == d + 1, "R1", k, d + 1, "first tick edge");
        repeat (d + 1) @(negedge clk);
        #1;
        chk(tick == 1'b1, "R1", int'(tick), 1, "next tick");
        if (d > 0) begin
            @(negedge clk);
            #1;
            chk(tick == 1'b0, "R1", int'(tick), 0, "gap after tick");
        end
        enable = 1'b0;
        @(negedge clk);
    endtask

    // R3 R5 R6: a run of nper periods that ends with a stop after a rise.
    task automatic run_case(input int d, input int s, input int c, input bit ll,
                            input int nper, input int stretch, input string tag);
        int p;
        int lo;
        int hi;
        int dl;
        p  = 20 + 8 * s + c;
        lo = (p + 1) / 2;
        hi = p - lo;
        dl = d + 1;
        @(negedge clk);
        #1;
        clk_cfg     = {6'(s), 3'(d)};
        comp_ticks  = 6'(c);
        lead_long   = ll;
        stretch_req = stretch;
        stretch_tok++;
        push(0, 1'b1, ll ? 17 : 6, "R5");
        for (int i = 0; i < nper; i++) begin
            push(1, 1'b0, lo * dl, tag);
            if (i < nper - 1)
                push(0, 1'b0, hi * dl + ((i == 0) ? stretch : 0), (i == 0 && stretch > 0) ? "R4" : tag);
        end
        enable = 1'b1;
        run    = 1'b1;
        wait_queue_empty();
        run = 1'b0;
        repeat (hi * dl + 6) @(negedge clk);
        #1;
        chk(scl_drive_low == 1'b0, "R6", int'(scl_drive_low), 0, "released after stop");
        enable = 1'b0;
        stretch_req = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: state held in reset
        chk(scl_drive_low == 1'b0, "R9", int'(scl_drive_low), 0, "pull-down in reset");
        chk(!scl_fall_stb && !scl_rise_stb, "R9", int'(scl_fall_stb | scl_rise_stb), 0, "strobes in reset");
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(tick == 1'b0, "R9", int'(tick), 0, "tick after reset");
        chk(scl_drive_low == 1'b0, "R9", int'(scl_drive_low), 0, "pull-down after reset");

        first_tick(3);
        first_tick(7);
        first_tick(0);

        run_case(0, 0, 0, 1'b0, 3, 0, "R3");   // P=20: 10/10 ticks
        run_case(3, 2, 5, 1'b1, 2, 0, "R3");   // P=41: 21/20 ticks at 4 clocks each
        run_case(7, 1, 3, 1'b0, 2, 0, "R2");   // top prescale value and packing
        run_case(0, 0, 1, 1'b0, 2, 7, "R3");   // P=21 with a 7-cycle stretch (R4)
        run_case(0, 63, 63, 1'b1, 1, 0, "R3"); // largest period, 587 ticks

        // R7: drop enable in the middle of a low phase
        @(negedge clk);
        #1;
        clk_cfg    = {6'd0, 3'd1};
        comp_ticks = 6'd0;
        lead_long  = 1'b0;
        push(0, 1'b1, 6, "R5");
        enable = 1'b1;
        run    = 1'b1;
        wait_queue_empty();
        chk(scl_drive_low == 1'b1, "R7", int'(scl_drive_low), 1, "low phase before disable");
        enable = 1'b0;
        run    = 1'b0;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R7", int'(scl_drive_low), 0, "released after disable");
        chk(tick == 1'b0, "R7", int'(tick), 0, "tick after disable");
        repeat (40) @(negedge clk);
        chk(scl_drive_low == 1'b0, "R7", int'(scl_drive_low), 0, "stays released");
        run_case(1, 3, 2, 1'b0, 2, 0, "R7");   // clean restart with full lead-in

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule